// File: doc/BRIEF.md
# SPI Engine with Select and Ready Handshake

This block is a serial engine that works either as the clock-owning side or as the clocked side of an SPI link. A single mode input chooses the role. Besides the clock and the two data lines, it carries a chip-select line and a ready line. The ready line lets a clocked-side unit tell the clock-owning side that new data is waiting.

The host loads a character through one of two write strobes that share a data bus. In the clock-owning role, the framed strobe pulls chip-select low for the whole character and releases it at the end. The plain strobe shifts a character and leaves chip-select alone, so the host can address a target by other means. Transfers use mode 0 with the MSB first. The clock half-period is set by a prescaler. A one-cycle done pulse marks each finished character, and the received character is then on the read port.

In the clocked role, the block brings the incoming clock, select and data in through two-flop synchronisers. A write goes into a holding buffer. The buffer moves into the shift register when the unit is selected and between characters. While data waits in the buffer and the unit is selected, the ready line is high. The ready line drops once the buffer is loaded, and it also drops whenever select is released. The block also produces output-enable signals for every pin, so that the pad ring can set pin directions.

Top module: `spi_hs_ctrl`

## Requirements
- R1: With `mode_master`=1 the block drives clock, MOSI and chip-select (`sclk_oe`, `mosi_oe`, `cs_oe` = 1; `miso_oe`, `ena_oe` = 0). With `mode_master`=0 it drives `ena_out` (`ena_oe`=1) and drives `miso_out` only while `cs_in` is low. In that role writes start no master transfer: `sclk_out` stays 0 and `cs_out` stays 1.
- R2: A `wr_framed` write in master role holds `cs_out` low on every cycle that `busy` is high for that character.
- R3: `cs_out` returns to 1 on the same cycle as the done pulse that ends a framed character.
- R4: A `wr_plain` write in master role shifts a character while `cs_out` stays 1 throughout.
- R5: In master role, `mosi_out` carries the written character MSB first, changing after falling clock edges. MISO is sampled on rising edges. The received character appears on `rd_data` together with a single-cycle `done` pulse.
- R6: In master role each clock half-period lasts `prescale`+1 system clocks, so `sclk_out` is high for W×(`prescale`+1) cycles per character.
- R7: In slave role, the MOSI bits sampled on W rising edges of `sclk_in` while selected are assembled MSB first into `rd_data`, with a single-cycle `done` pulse.
- R8: In slave role, the character written and loaded is presented on `miso_out` MSB first. The first bit is valid before the first rising edge, and the next bit follows each falling edge.
- R9: In slave role, `ena_out` is 1 while a written character waits in the buffer and the unit is selected.
- R10: In slave role, `ena_out` goes to 0 once the waiting character has moved into the shift register.
- R11: In slave role, `ena_out` is 0 whenever `cs_in` is high, even with a character pending.
- R12: After reset `cs_out`=1, `sclk_out`=0, `done`=0, `busy`=0, `rd_data`=0 and `ena_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_master | input | 1 | 1 = clock-owning role, 0 = clocked role |
| prescale | input | PW | Half-period of serial clock minus one, in system clocks |
| wr_framed | input | 1 | Write strobe that frames the character with chip-select |
| wr_plain | input | 1 | Write strobe with no chip-select change |
| wr_data | input | DW | Character to transmit |
| rd_data | output | DW | Last received character |
| done | output | 1 | One-cycle pulse at end of character |
| busy | output | 1 | Master transfer in progress |
| sclk_out | output | 1 | Serial clock driven in master role |
| sclk_in | input | 1 | Serial clock received in slave role |
| sclk_oe | output | 1 | Output enable of clock pin |
| mosi_out | output | 1 | Master data out |
| mosi_in | input | 1 | Slave data in |
| mosi_oe | output | 1 | Output enable of MOSI pin |
| miso_out | output | 1 | Slave data out |
| miso_in | input | 1 | Master data in |
| miso_oe | output | 1 | Output enable of MISO pin |
| cs_out | output | 1 | Active-low chip-select, master role |
| cs_in | input | 1 | Active-low chip-select, slave role |
| cs_oe | output | 1 | Output enable of chip-select pin |
| ena_out | output | 1 | Ready line, high while loaded data waits |
| ena_oe | output | 1 | Output enable of ready pin |

## Verification
A wrong divider or bit counter in the master shows on the ports within one character. The high-time count of `sclk_out` no longer matches W×(`prescale`+1), or `done` arrives early or late. Either way `rd_data` and the bits collected from `mosi_out` no longer match the vectors. A stuck framing flag shows as a chip-select level that is wrong on the first busy cycle. In slave role, a pending flag that never clears keeps `ena_out` high a few cycles after a character boundary. A missed load shows as a wrong MISO bit on the very next character.

// File: rtl/spi_hs_pkg.sv
package spi_hs_pkg;
    typedef enum logic {
        M_IDLE = 1'b0,
        M_XFER = 1'b1
    } mst_state_e;

    typedef struct packed {
        logic sclk;
        logic cs_n;
        logic mosi;
    } slv_pins_t;

    localparam slv_pins_t SLV_PINS_IDLE = '{sclk: 1'b0, cs_n: 1'b1, mosi: 1'b0};

    function automatic logic [63:0] shl_in(input logic [63:0] sr, input logic b);
        return {sr[62:0], b};
    endfunction
endpackage

// File: rtl/spi_hs_sync.sv
module spi_hs_sync #(
    parameter int         W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/spi_hs_master.sv
module spi_hs_master
    import spi_hs_pkg::*;
#(
    parameter int DW = 8,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          start_framed,
    input  logic          start_plain,
    input  logic [DW-1:0] wr_data,
    input  logic [PW-1:0] prescale,
    input  logic          miso,
    output logic          sclk,
    output logic          mosi,
    output logic          cs_n,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rx_data
);
    localparam int BW = (DW > 1) ? $clog2(DW) : 1;

    mst_state_e    state_q;
    logic [PW-1:0] div_q;
    logic [BW-1:0] bit_q;
    logic [DW-1:0] tx_q;
    logic [DW-1:0] rx_q;
    logic          sclk_q;
    logic          cs_n_q;
    logic          framed_q;
    logic          done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= M_IDLE;
            div_q    <= '0;
            bit_q    <= '0;
            tx_q     <= '0;
            rx_q     <= '0;
            rx_data  <= '0;
            sclk_q   <= 1'b0;
            cs_n_q   <= 1'b1;
            framed_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                M_IDLE: begin
                    if (en && (start_framed || start_plain)) begin
                        tx_q     <= wr_data;
                        framed_q <= start_framed;
                        cs_n_q   <= !start_framed;
                        div_q    <= '0;
                        bit_q    <= '0;
                        state_q  <= M_XFER;
                    end
                end
                M_XFER: begin
                    if (div_q == prescale) begin
                        div_q <= '0;
                        if (!sclk_q) begin
                            sclk_q <= 1'b1;
                            rx_q   <= shl_in(64'(rx_q), miso)[DW-1:0];
                        end else begin
                            sclk_q <= 1'b0;
                            if (bit_q == BW'(DW - 1)) begin
                                state_q <= M_IDLE;
                                done_q  <= 1'b1;
                                cs_n_q  <= 1'b1;
                                rx_data <= rx_q;
                            end else begin
                                tx_q  <= tx_q << 1;
                                bit_q <= bit_q + 1'b1;
                            end
                        end
                    end else begin
                        div_q <= div_q + 1'b1;
                    end
                end
                default: state_q <= M_IDLE;
            endcase
        end
    end

    assign sclk = sclk_q;
    assign mosi = tx_q[DW-1];
    assign cs_n = cs_n_q;
    assign busy = (state_q == M_XFER);
    assign done = done_q;

    // R2
    framed_cs_low_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == M_XFER && framed_q) |-> !cs_n_q);
    // R4
    plain_cs_high_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == M_XFER && !framed_q) |-> cs_n_q);
    // R3
    cs_release_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> cs_n_q);
    // R6
    sclk_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (sclk_q != $past(sclk_q)) |-> ($past(div_q) == $past(prescale)));
    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
endmodule

// File: rtl/spi_hs_slave.sv
module spi_hs_slave
    import spi_hs_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          wr,
    input  logic [DW-1:0] wr_data,
    input  logic          sclk_in,
    input  logic          cs_n_in,
    input  logic          mosi_in,
    output logic          miso,
    output logic          ena,
    output logic          done,
    output logic [DW-1:0] rx_data
);
    localparam int BW = (DW > 1) ? $clog2(DW) : 1;

    slv_pins_t     pins_s;
    logic          sclk_d;
    logic          pending_q;
    logic [DW-1:0] buf_q;
    logic [DW-1:0] tx_q;
    logic [DW-1:0] rx_q;
    logic [BW-1:0] cnt_q;
    logic          done_q;
    logic          selected;
    logic          rise;
    logic          fall;

    spi_hs_sync #(.W(3), .RST_VAL(SLV_PINS_IDLE)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sclk_in, cs_n_in, mosi_in}),
        .q   (pins_s)
    );

    assign selected = en && !pins_s.cs_n;
    assign rise     = pins_s.sclk && !sclk_d;
    assign fall     = !pins_s.sclk && sclk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d    <= 1'b0;
            pending_q <= 1'b0;
            buf_q     <= '0;
            tx_q      <= '0;
            rx_q      <= '0;
            rx_data   <= '0;
            cnt_q     <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            sclk_d <= pins_s.sclk;
            if (!selected) begin
                cnt_q <= '0;
            end else if (rise) begin
                rx_q <= shl_in(64'(rx_q), pins_s.mosi)[DW-1:0];
                if (cnt_q == BW'(DW - 1)) begin
                    cnt_q   <= '0;
                    done_q  <= 1'b1;
                    rx_data <= shl_in(64'(rx_q), pins_s.mosi)[DW-1:0];
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else if (fall && cnt_q != '0) begin
                tx_q <= tx_q << 1;
            end else if (cnt_q == '0 && pending_q) begin
                tx_q      <= buf_q;
                pending_q <= 1'b0;
            end
            if (en && wr) begin
                buf_q     <= wr_data;
                pending_q <= 1'b1;
            end
        end
    end

    assign miso = tx_q[DW-1];
    assign ena  = selected && pending_q;
    assign done = done_q;

    // R7
    slv_done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
    // R10
    slv_load_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (selected && !rise && !fall && cnt_q == '0 && pending_q && !(en && wr)) |=> !pending_q);
endmodule

// File: rtl/spi_hs_ctrl.sv
module spi_hs_ctrl #(
    parameter int DW = 8,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_master,
    input  logic [PW-1:0] prescale,
    input  logic          wr_framed,
    input  logic          wr_plain,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic          done,
    output logic          busy,
    output logic          sclk_out,
    input  logic          sclk_in,
    output logic          sclk_oe,
    output logic          mosi_out,
    input  logic          mosi_in,
    output logic          mosi_oe,
    output logic          miso_out,
    input  logic          miso_in,
    output logic          miso_oe,
    output logic          cs_out,
    input  logic          cs_in,
    output logic          cs_oe,
    output logic          ena_out,
    output logic          ena_oe
);
    logic [DW-1:0] m_rx;
    logic [DW-1:0] s_rx;
    logic          m_done;
    logic          s_done;

    spi_hs_master #(.DW(DW), .PW(PW)) u_master (
        .clk          (clk),
        .rst          (rst),
        .en           (mode_master),
        .start_framed (wr_framed),
        .start_plain  (wr_plain),
        .wr_data      (wr_data),
        .prescale     (prescale),
        .miso         (miso_in),
        .sclk         (sclk_out),
        .mosi         (mosi_out),
        .cs_n         (cs_out),
        .busy         (busy),
        .done         (m_done),
        .rx_data      (m_rx)
    );

    spi_hs_slave #(.DW(DW)) u_slave (
        .clk     (clk),
        .rst     (rst),
        .en      (!mode_master),
        .wr      (wr_framed || wr_plain),
        .wr_data (wr_data),
        .sclk_in (sclk_in),
        .cs_n_in (cs_in),
        .mosi_in (mosi_in),
        .miso    (miso_out),
        .ena     (ena_out),
        .done    (s_done),
        .rx_data (s_rx)
    );

    assign rd_data = mode_master ? m_rx : s_rx;
    assign done    = m_done || s_done;
    assign sclk_oe = mode_master;
    assign mosi_oe = mode_master;
    assign cs_oe   = mode_master;
    assign ena_oe  = !mode_master;
    assign miso_oe = !mode_master && !cs_in;

    // R11
    desel_ena_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode_master && cs_in && $past(cs_in) && $past(cs_in, 2)) |-> !ena_out);
    // R1
    slave_no_sclk_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode_master && !$past(busy)) |-> (!sclk_out && cs_out));
endmodule

// File: tb/test_spi_hs_ctrl.sv
module test_spi_hs_ctrl;
    localparam int DW = 8;
    localparam int PW = 8;
    localparam int H  = 8;

    typedef struct packed {
        logic          framed;
        logic [DW-1:0] tx;
        logic [DW-1:0] pat;
        logic [PW-1:0] pre;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{framed: 1'b1, tx: 8'hA5, pat: 8'h3C, pre: 8'd1},
        '{framed: 1'b0, tx: 8'h81, pat: 8'hE7, pre: 8'd0},
        '{framed: 1'b1, tx: 8'h00, pat: 8'hFF, pre: 8'd3},
        '{framed: 1'b0, tx: 8'h7E, pat: 8'h01, pre: 8'd2}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_master = 1'b1;
    logic [PW-1:0] prescale = '0;
    logic wr_framed = 1'b0, wr_plain = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic done, busy, sclk_out, sclk_oe, mosi_out, mosi_oe, miso_out, miso_oe;
    logic cs_out, cs_oe, ena_out, ena_oe;
    logic sclk_in = 1'b0, mosi_in = 1'b0, cs_in = 1'b1;
    logic [DW-1:0] bm_tx = '0;
    logic [DW-1:0] bm_rx = '0;
    logic miso_in;

    int tests = 0, fails = 0;
    int done_cnt, cs_hi_busy, cs_lo_busy, sclk_hi;
    logic cs_at_done;

    always #5 clk = ~clk;

    spi_hs_ctrl #(.DW(DW), .PW(PW)) i_spi_hs_ctrl (
        .clk(clk), .rst(rst), .mode_master(mode_master), .prescale(prescale),
        .wr_framed(wr_framed), .wr_plain(wr_plain), .wr_data(wr_data),
        .rd_data(rd_data), .done(done), .busy(busy),
        .sclk_out(sclk_out), .sclk_in(sclk_in), .sclk_oe(sclk_oe),
        .mosi_out(mosi_out), .mosi_in(mosi_in), .mosi_oe(mosi_oe),
        .miso_out(miso_out), .miso_in(miso_in), .miso_oe(miso_oe),
        .cs_out(cs_out), .cs_in(cs_in), .cs_oe(cs_oe),
        .ena_out(ena_out), .ena_oe(ena_oe)
    );

    // bench model of the remote target in master role
    assign miso_in = bm_tx[DW-1];
    always @(negedge sclk_out) bm_tx <= bm_tx << 1;
    always @(posedge sclk_out) bm_rx <= {bm_rx[DW-2:0], mosi_out};

    // port monitor sampled away from the active edge
    always @(negedge clk) begin
        if (busy) begin
            if (cs_out) cs_hi_busy++;
            else        cs_lo_busy++;
            if (sclk_out) sclk_hi++;
        end
        if (done) begin
            done_cnt++;
            cs_at_done = cs_out;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        done_cnt = 0; cs_hi_busy = 0; cs_lo_busy = 0; sclk_hi = 0; cs_at_done = 1'b0;
    endtask

    task automatic host_write(input logic framed, input logic [DW-1:0] d);
        @(negedge clk);
        wr_data   = d;
        wr_framed = framed;
        wr_plain  = !framed;
        @(negedge clk);
        wr_framed = 1'b0;
        wr_plain  = 1'b0;
    endtask

    task automatic wait_done();
        for (int k = 0; k < 2000 && done_cnt == 0; k++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic slv_xfer(input logic [DW-1:0] mo, input int nbits, input int wr_at,
                            input logic [DW-1:0] wr_val, output logic [DW-1:0] got);
        got = '0;
        for (int i = 0; i < nbits; i++) begin
            mosi_in = mo[DW-1-i];
            if (i == wr_at) begin
                host_write(1'b0, wr_val);
                repeat (2) @(negedge clk);
                chk("R9 ena high with pending data while selected", 32'(ena_out), 32'd1);
            end
            repeat (H) @(negedge clk);
            got[DW-1-i] = miso_out;
            sclk_in = 1'b1;
            repeat (H) @(negedge clk);
            sclk_in = 1'b0;
        end
        repeat (H) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [DW-1:0] got;
        clear_mon();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk("R12 cs_out", 32'(cs_out), 32'd1);
        chk("R12 sclk_out", 32'(sclk_out), 32'd0);
        chk("R12 done/busy", 32'({done, busy}), 32'd0);
        chk("R12 rd_data", 32'(rd_data), 32'd0);
        chk("R12 ena_out", 32'(ena_out), 32'd0);
        // R1 master role directions
        chk("R1 master oe {sclk,mosi,cs,miso,ena}",
            32'({sclk_oe, mosi_oe, cs_oe, miso_oe, ena_oe}), 32'b11100);

        // vector table: master transfers
        foreach (VECS[v]) begin
            prescale = VECS[v].pre;
            bm_tx    = VECS[v].pat;
            clear_mon();
            host_write(VECS[v].framed, VECS[v].tx);
            wait_done();
            chk("R5 rd_data", 32'(rd_data), 32'(VECS[v].pat));
            chk("R5 mosi bits", 32'(bm_rx), 32'(VECS[v].tx));
            chk("R5 done count", 32'(done_cnt), 32'd1);
            chk("R6 sclk high cycles", 32'(sclk_hi), 32'(DW * (VECS[v].pre + 1)));
            if (VECS[v].framed) begin
                chk("R2 cs high while busy", 32'(cs_hi_busy), 32'd0);
                chk("R3 cs at done", 32'(cs_at_done), 32'd1);
            end else begin
                chk("R4 cs low while busy", 32'(cs_lo_busy), 32'd0);
            end
            chk("R5 sclk idle low", 32'(sclk_out), 32'd0);
        end

        // slave role
        mode_master = 1'b0;
        cs_in = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 slave oe {sclk,mosi,cs,miso,ena}",
            32'({sclk_oe, mosi_oe, cs_oe, miso_oe, ena_oe}), 32'b00001);
        host_write(1'b1, 8'hC3);
        repeat (4) @(negedge clk);
        chk("R1 slave write starts no clock/cs", 32'({sclk_out, cs_out}), 32'b01);
        chk("R11 ena low while deselected with pending", 32'(ena_out), 32'd0);
        cs_in = 1'b0;
        repeat (6) @(negedge clk);
        chk("R1 miso_oe when selected", 32'(miso_oe), 32'd1);
        chk("R10 ena low after load", 32'(ena_out), 32'd0);
        clear_mon();
        slv_xfer(8'h5A, DW, -1, '0, got);
        chk("R8 miso bits", 32'(got), 32'hC3);
        chk("R7 rd_data", 32'(rd_data), 32'h5A);
        chk("R7 done count", 32'(done_cnt), 32'd1);

        // write mid-character: pending until boundary
        slv_xfer(8'hB1, DW, 3, 8'h96, got);
        chk("R7 rd_data second", 32'(rd_data), 32'hB1);
        repeat (6) @(negedge clk);
        chk("R10 ena low after boundary load", 32'(ena_out), 32'd0);
        slv_xfer(8'h0F, DW, -1, '0, got);
        chk("R8 miso bits after boundary load", 32'(got), 32'h96);

        // deselect with pending data
        slv_xfer(8'h00, 3, 1, 8'h44, got);
        cs_in = 1'b1;
        repeat (4) @(negedge clk);
        chk("R11 ena low after deselect", 32'(ena_out), 32'd0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule